// File: doc/BRIEF.md
# Prioritized Pending Interrupt Arbiter

This block keeps one pending bit for each of fourteen interrupt sources and, in every cycle, names the single source that a processor core should take next. Each source raises its bit with a one-cycle set pulse. The arbiter then combines the pending bits with the core's state enables (external enable, critical enable, hypervisor state) and two control bits: the hypervisor-decrementer enable and the external-routing bit. From these it finds the deliverable sources and presents the one with the highest priority as a valid/ID pair.

When the core accepts the offered interrupt it pulses a take acknowledge. The arbiter then clears the chosen pending bit, but only for sources that clear on delivery. External and critical-external requests are level-type and stay pending until their own clear pulse arrives. A per-source clear input lets a source withdraw its request. Entering a power-save state drops any pending hypervisor decrementer. Whether the decrementer clears on delivery is set by a configuration input.

Top module: `irq_prio_arbiter`

## Requirements
- R1: After reset, all pending bits are zero and `irqValid` is low.
- R2: Source IDs follow priority order, and a lower ID always wins: 0 reset, 1 machine check, 2 hypervisor decrementer, 3 external, 4 critical external, 5 watchdog, 6 critical doorbell, 7 fixed-interval timer, 8 programmable interval timer, 9 decrementer, 10 doorbell, 11 hypervisor doorbell, 12 performance monitor, 13 thermal. Bit k of `setPulse`, `clrPulse` and `pendingVec` belongs to ID k.
- R3: Sources 0 and 1 are deliverable whenever they are pending, whatever the enables, and a take clears them.
- R4: Source 2 is deliverable only when `hdecIntEn` is 1 and either `eeBit` is 1 or `hvBit` is 0. A take clears it.
- R5: Source 3 is deliverable when `eeBit` is 1, or when `hypPresent` is 1, `hvBit` is 0 and `extGuestRoute` is 0. A take does not clear it.
- R6: Source 4 is deliverable only when `ceBit` is 1. A take does not clear it.
- R7: Sources 5 to 13 are deliverable only when `eeBit` is 1, and a take clears them (source 9 is the exception, see R8).
- R8: A take clears source 9 only when `decClrOnTake` is 1.
- R9: A cycle with `pwrSaveEnter` high clears pending source 2.
- R10: If a set pulse and any clear (a `clrPulse` bit, a take, or power-save entry) hit the same bit in the same cycle, the bit ends up set.
- R11: `irqValid` is the OR of all deliverable sources. A `takeAck` while `irqValid` is low changes nothing.
- R12: A set pulse shows in `pendingVec` one clock later. `irqValid` and `irqId` follow `pendingVec` and the enables combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| setPulse | input | 14 | Per-source request pulses |
| clrPulse | input | 14 | Per-source withdraw pulses |
| takeAck | input | 1 | Core accepts the offered interrupt |
| pwrSaveEnter | input | 1 | Core enters a power-save state |
| decClrOnTake | input | 1 | Decrementer clears on delivery |
| eeBit | input | 1 | External interrupt enable state |
| ceBit | input | 1 | Critical interrupt enable state |
| hvBit | input | 1 | Core is in hypervisor state |
| hypPresent | input | 1 | Hypervisor mode implemented |
| hdecIntEn | input | 1 | Hypervisor decrementer interrupt enable |
| extGuestRoute | input | 1 | External interrupts kept in guest routing |
| irqValid | output | 1 | An interrupt is deliverable |
| irqId | output | 4 | ID of the offered interrupt |
| pendingVec | output | 14 | Pending bits |

## Verification
On every cycle the assertions check these rules: a set pulse wins against any clear, an offered ID is always pending, a pending reset source is always the one offered, nothing above ID 4 is offered while the external enable is low, a critical-external bit survives its own take, and power-save entry drops the hypervisor decrementer. The bench compares every cycle against a model built from the requirements. Only its scenarios can show that the gating truth tables for the hypervisor decrementer and the external source are complete, that the decrementer clear depends on the configuration input, and that the whole priority order across mixed random traffic is correct.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int NUM_SRC = 14;
  localparam int ID_W    = $clog2(NUM_SRC);

  typedef enum logic [ID_W-1:0] {
    SRC_RESET  = 4'd0,
    SRC_MCHK   = 4'd1,
    SRC_HDEC   = 4'd2,
    SRC_EXT    = 4'd3,
    SRC_CRIT   = 4'd4,
    SRC_WDOG   = 4'd5,
    SRC_CDBELL = 4'd6,
    SRC_FIT    = 4'd7,
    SRC_PIT    = 4'd8,
    SRC_DEC    = 4'd9,
    SRC_DBELL  = 4'd10,
    SRC_HDBELL = 4'd11,
    SRC_PERF   = 4'd12,
    SRC_THERM  = 4'd13
  } src_id_e;

  // Strobes from control to the pending datapath
  typedef struct packed {
    logic            take;     // accepted delivery this cycle
    logic [ID_W-1:0] takeId;   // which source was delivered
    logic            dropHdec; // power-save entry discards hyp decrementer
  } arb_strobe_t;
endpackage

// File: rtl/irq_arb_ctrl.sv
module irq_arb_ctrl
  import irq_arb_pkg::*;
(
  input  logic [NUM_SRC-1:0] pendingVec,
  input  logic               takeAck,
  input  logic               pwrSaveEnter,
  input  logic               eeBit,
  input  logic               ceBit,
  input  logic               hvBit,
  input  logic               hypPresent,
  input  logic               hdecIntEn,
  input  logic               extGuestRoute,
  output logic               irqValid,
  output logic [ID_W-1:0]    irqId,
  output arb_strobe_t        strobe
);
  logic [NUM_SRC-1:0] gateOk;
  logic [NUM_SRC-1:0] deliverable;
  logic [ID_W-1:0]    selId;

  // Per-source gating conditions
  genvar k;
  generate
    for (k = 0; k < NUM_SRC; k++) begin : g_gate
      if (k == SRC_RESET || k == SRC_MCHK) begin : g_always
        assign gateOk[k] = 1'b1;
      end else if (k == SRC_HDEC) begin : g_hdec
        assign gateOk[k] = hdecIntEn & (eeBit | ~hvBit);
      end else if (k == SRC_EXT) begin : g_ext
        assign gateOk[k] = eeBit | (hypPresent & ~hvBit & ~extGuestRoute);
      end else if (k == SRC_CRIT) begin : g_crit
        assign gateOk[k] = ceBit;
      end else begin : g_ee
        assign gateOk[k] = eeBit;
      end
    end
  endgenerate

  assign deliverable = pendingVec & gateOk;

  // Fixed priority: lowest index wins
  always_comb begin
    selId = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (deliverable[i]) selId = ID_W'(i);
    end
  end

  assign irqValid        = |deliverable;
  assign irqId           = selId;
  assign strobe.take     = takeAck & irqValid;
  assign strobe.takeId   = selId;
  assign strobe.dropHdec = pwrSaveEnter;
endmodule

// File: rtl/irq_arb_pend.sv
module irq_arb_pend
  import irq_arb_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] setPulse,
  input  logic [NUM_SRC-1:0] clrPulse,
  input  logic               decClrOnTake,
  input  arb_strobe_t        strobe,
  output logic [NUM_SRC-1:0] pendingVec
);
  logic [NUM_SRC-1:0] pendQ;
  logic [NUM_SRC-1:0] takeHit;
  logic [NUM_SRC-1:0] clearsOnTake;
  logic [NUM_SRC-1:0] clrAll;

  genvar k;
  generate
    for (k = 0; k < NUM_SRC; k++) begin : g_bit
      assign takeHit[k] = strobe.take & (strobe.takeId == ID_W'(k));

      if (k == SRC_EXT || k == SRC_CRIT) begin : g_level
        assign clearsOnTake[k] = 1'b0;
      end else if (k == SRC_DEC) begin : g_dec
        assign clearsOnTake[k] = decClrOnTake;
      end else begin : g_pulse
        assign clearsOnTake[k] = 1'b1;
      end

      if (k == SRC_HDEC) begin : g_pwr
        assign clrAll[k] = clrPulse[k] | (takeHit[k] & clearsOnTake[k]) | strobe.dropHdec;
      end else begin : g_nopwr
        assign clrAll[k] = clrPulse[k] | (takeHit[k] & clearsOnTake[k]);
      end

      // set wins over every clear
      always_ff @(posedge clk) begin
        if (!rstN) pendQ[k] <= 1'b0;
        else       pendQ[k] <= setPulse[k] | (pendQ[k] & ~clrAll[k]);
      end
    end
  endgenerate

  assign pendingVec = pendQ;
endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
  import irq_arb_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] setPulse,
  input  logic [NUM_SRC-1:0] clrPulse,
  input  logic               takeAck,
  input  logic               pwrSaveEnter,
  input  logic               decClrOnTake,
  input  logic               eeBit,
  input  logic               ceBit,
  input  logic               hvBit,
  input  logic               hypPresent,
  input  logic               hdecIntEn,
  input  logic               extGuestRoute,
  output logic               irqValid,
  output logic [ID_W-1:0]    irqId,
  output logic [NUM_SRC-1:0] pendingVec
);
  arb_strobe_t strobe;

  irq_arb_ctrl i_ctrl (
    .pendingVec   (pendingVec),
    .takeAck      (takeAck),
    .pwrSaveEnter (pwrSaveEnter),
    .eeBit        (eeBit),
    .ceBit        (ceBit),
    .hvBit        (hvBit),
    .hypPresent   (hypPresent),
    .hdecIntEn    (hdecIntEn),
    .extGuestRoute(extGuestRoute),
    .irqValid     (irqValid),
    .irqId        (irqId),
    .strobe       (strobe)
  );

  irq_arb_pend i_pend (
    .clk         (clk),
    .rstN        (rstN),
    .setPulse    (setPulse),
    .clrPulse    (clrPulse),
    .decClrOnTake(decClrOnTake),
    .strobe      (strobe),
    .pendingVec  (pendingVec)
  );
endmodule

// File: rtl/irq_arb_chk.sv
module irq_arb_chk
  import irq_arb_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] setPulse,
  input logic [NUM_SRC-1:0] clrPulse,
  input logic               takeAck,
  input logic               pwrSaveEnter,
  input logic               eeBit,
  input logic               irqValid,
  input logic [ID_W-1:0]    irqId,
  input logic [NUM_SRC-1:0] pendingVec
);
  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|setPulse) |=> ((pendingVec & $past(setPulse)) == $past(setPulse)));

  // R2
  offered_pending_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqValid |-> pendingVec[irqId]);

  // R3
  reset_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    pendingVec[SRC_RESET] |-> (irqValid && irqId == SRC_RESET));

  // R7
  ee_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!eeBit && irqValid) |-> (irqId <= SRC_CRIT));

  // R6
  crit_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (takeAck && irqValid && irqId == SRC_CRIT && !clrPulse[SRC_CRIT]) |=> pendingVec[SRC_CRIT]);

  // R9
  pwr_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pwrSaveEnter && !setPulse[SRC_HDEC]) |=> !pendingVec[SRC_HDEC]);
endmodule

bind irq_prio_arbiter irq_arb_chk i_chk (
  .clk         (clk),
  .rstN        (rstN),
  .setPulse    (setPulse),
  .clrPulse    (clrPulse),
  .takeAck     (takeAck),
  .pwrSaveEnter(pwrSaveEnter),
  .eeBit       (eeBit),
  .irqValid    (irqValid),
  .irqId       (irqId),
  .pendingVec  (pendingVec)
);

// File: tb/test_irq_prio_arbiter.sv
module test_irq_prio_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 14;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NS-1:0] setPulse = '0, clrPulse = '0;
  logic takeAck = 0, pwrSaveEnter = 0, decClrOnTake = 0;
  logic eeBit = 0, ceBit = 0, hvBit = 0, hypPresent = 0, hdecIntEn = 0, extGuestRoute = 0;
  logic irqValid;
  logic [3:0] irqId;
  logic [NS-1:0] pendingVec;

  int vectors = 0, miscompares = 0;
  bit finished = 0;
  logic [NS-1:0] pModel = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_prio_arbiter i_irq_prio_arbiter (
    .clk(clk), .rstN(rstN), .setPulse(setPulse), .clrPulse(clrPulse),
    .takeAck(takeAck), .pwrSaveEnter(pwrSaveEnter), .decClrOnTake(decClrOnTake),
    .eeBit(eeBit), .ceBit(ceBit), .hvBit(hvBit), .hypPresent(hypPresent),
    .hdecIntEn(hdecIntEn), .extGuestRoute(extGuestRoute),
    .irqValid(irqValid), .irqId(irqId), .pendingVec(pendingVec)
  );

  // Deliverable set per R3..R7
  function automatic logic [NS-1:0] eligible(input logic [NS-1:0] p);
    logic [NS-1:0] g;
    g = '0;
    g[0] = 1'b1;
    g[1] = 1'b1;
    g[2] = hdecIntEn & (eeBit | ~hvBit);
    g[3] = eeBit | (hypPresent & ~hvBit & ~extGuestRoute);
    g[4] = ceBit;
    for (int i = 5; i < NS; i++) g[i] = eeBit;
    return p & g;
  endfunction

  function automatic int pickId(input logic [NS-1:0] e);
    for (int i = 0; i < NS; i++) if (e[i]) return i;
    return 0;
  endfunction

  // Next pending per R8..R11
  function automatic logic [NS-1:0] nextPend(input logic [NS-1:0] p);
    logic [NS-1:0] e, clr, mask;
    e = eligible(p);
    mask = {NS{1'b1}};
    mask[3] = 1'b0;
    mask[4] = 1'b0;
    mask[9] = decClrOnTake;
    clr = clrPulse;
    if (takeAck && (|e)) clr[pickId(e)] = clr[pickId(e)] | mask[pickId(e)];
    if (pwrSaveEnter) clr[2] = 1'b1;
    return (p & ~clr) | setPulse;
  endfunction

  task automatic step(input string tag);
    logic [NS-1:0] e;
    int eid;
    #1;
    e = eligible(pModel);
    eid = pickId(e);
    vectors++;
    if (irqValid !== (|e) || ((|e) && irqId !== 4'(eid)) || pendingVec !== pModel) begin
      miscompares++;
      $display("FAIL %s: valid/id/pend actual %0b/%0d/%h expected %0b/%0d/%h",
               tag, irqValid, irqId, pendingVec, |e, eid, pModel);
    end
    @(posedge clk);
    pModel = nextPend(pModel);
    @(negedge clk);
    setPulse = '0; clrPulse = '0; takeAck = 0; pwrSaveEnter = 0;
  endtask

  task automatic clearAll();
    clrPulse = '1;
    step("R11");
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    step("R1");                                   // R1 reset state

    // R12 / R7: decrementer pending but EE low
    setPulse[9] = 1; step("R12");
    step("R7");
    eeBit = 1; step("R7");
    decClrOnTake = 0; takeAck = 1; step("R8");   // R8 stays pending
    decClrOnTake = 1; takeAck = 1; step("R8");   // R8 cleared
    step("R8");

    // R2 ordering among EE group
    setPulse[13] = 1; setPulse[5] = 1; setPulse[11] = 1; step("R2");
    step("R2");
    takeAck = 1; step("R2");
    step("R2");
    clearAll();

    // R3 machine check with everything disabled
    eeBit = 0; ceBit = 0;
    setPulse[1] = 1; setPulse[4] = 1; step("R3");
    takeAck = 1; step("R3");
    step("R3");
    clearAll();

    // R4 hypervisor decrementer gating
    setPulse[2] = 1; hdecIntEn = 0; hvBit = 0; step("R4");
    step("R4");
    hdecIntEn = 1; hvBit = 1; step("R4");
    hvBit = 0; step("R4");
    eeBit = 1; hvBit = 1; takeAck = 1; step("R4");
    step("R4");

    // R5 external bypass of EE, not cleared on take
    eeBit = 0; hvBit = 0; hypPresent = 1; extGuestRoute = 1;
    setPulse[3] = 1; step("R5");
    step("R5");
    extGuestRoute = 0; step("R5");
    takeAck = 1; step("R5");
    step("R5");
    hypPresent = 0; step("R5");
    clearAll();

    // R6 critical external sticky
    setPulse[4] = 1; ceBit = 1; step("R6");
    takeAck = 1; step("R6");
    step("R6");
    ceBit = 0; step("R6");
    clearAll();

    // R9 power-save drops hyp decrementer
    setPulse[2] = 1; step("R9");
    pwrSaveEnter = 1; step("R9");
    step("R9");

    // R10 set wins over clear and over take
    setPulse[10] = 1; clrPulse[10] = 1; step("R10");
    eeBit = 1; step("R10");
    takeAck = 1; setPulse[10] = 1; step("R10");
    step("R10");
    setPulse[2] = 1; pwrSaveEnter = 1; step("R10");
    step("R10");
    clearAll();

    // R11 take with nothing deliverable
    eeBit = 0; setPulse[9] = 1; step("R11");
    takeAck = 1; step("R11");
    step("R11");
    clearAll();

    // Random traffic, R2 across all rules
    for (int n = 0; n < 3000; n++) begin
      eeBit = $urandom % 2; ceBit = $urandom % 2; hvBit = $urandom % 2;
      hypPresent = $urandom % 2; hdecIntEn = $urandom % 2;
      extGuestRoute = $urandom % 2; decClrOnTake = $urandom % 2;
      for (int b = 0; b < NS; b++) begin
        setPulse[b] = ($urandom % 10) == 0;
        clrPulse[b] = ($urandom % 14) == 0;
      end
      if (($urandom % 3) != 0) setPulse[0] = 0;
      takeAck = $urandom % 2;
      pwrSaveEnter = ($urandom % 16) == 0;
      step("R2");
    end
    finish();
  end
endmodule